// File: doc/BRIEF.md
# Serial NOR Flash Status Register and Write-Protection Guard

This block keeps the eight-bit status register of a small serial NOR flash and decides, for every decoded request coming from the SPI command front-end, whether that request may proceed. It handles the write-enable latch, the status-register write, and the program and erase permission check. It also enforces a hardware lock that is controlled by the write-protect pin. The array's program and erase time is modelled by an internal busy counter. The counter drives the in-progress flag and clears the write-enable latch when the operation finishes.

Each request is one cycle wide. It carries a kind code, a data byte for status writes, a 24-bit byte address and an erase-size code. One cycle later the block returns a response pulse with an accept flag. The status byte is always visible at the output. Program and erase targets are checked against the protected range that the four-bit block-protect field selects for a 512-kB (4-Mbit) array. That mapping is not uniform: some codes guard the top of the array, some guard all of it, some guard nothing, and some guard a lower range that leaves a small top slice writable.

Top module: `nor_status_guard`

## Requirements
- R1: The status byte is laid out as follows: bit 0 busy (in progress), bit 1 write-enable latch, bits 5:2 block-protect code, bit 6 always 0, bit 7 status lock. After reset it reads 00h and no response is pending.
- R2: Request kind codes are 0 status read, 1 write enable, 2 write disable, 3 status write, 4 page program, 5 erase, with 6 and 7 always rejected. respValid pulses in the cycle after any request and carries the verdict. While the block is idle, write enable sets the latch and write disable clears it.
- R3: A status write, program or erase is rejected and changes nothing when the write-enable latch is 0.
- R4: An accepted status write loads bit 7 and bits 5:2 from the data byte. Bit 6 stays 0, and the busy flag and the write-enable latch do not take the written values.
- R5: When the status lock (bit 7) is 1 and wpN is low, status writes are rejected. With wpN high they are accepted.
- R6: Protect codes 0001, 0010 and 0011 guard 070000h-07FFFFh, 060000h-07FFFFh and 040000h-07FFFFh.
- R7: Codes 0000 and 1000 guard nothing. Codes 0100 through 0111 and 1111 guard the whole array.
- R8: Codes 1001 through 1110 guard 000000h up to 07EFFFh, 07DFFFh, 07BFFFh, 077FFFh, 05FFFFh and 03FFFFh respectively.
- R9: The target of a program is its aligned 256-byte page. The target of an erase is its aligned 4-kB sector for size code 0, its aligned 64-kB block for size code 1, and the whole chip for size code 2. Size code 3 is rejected. A request is rejected if any byte of its target lies in the guarded range.
- R10: A whole-chip erase is rejected whenever the protect code is non-zero, including code 1000.
- R11: An accepted status write, program or erase holds the busy flag for BUSY_CYCLES cycles. The write-enable latch clears when that period ends.
- R12: While busy, every request except the status read is rejected, including write enable and write disable. Status reads are always accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | One-cycle request strobe |
| reqKind | input | 3 | Request kind code (see R2) |
| reqData | input | 8 | Data byte for a status write |
| reqAddr | input | 24 | Byte address for program or erase |
| reqSize | input | 2 | Erase size code (see R9) |
| wpN | input | 1 | Write-protect pin, active low |
| respValid | output | 1 | Response strobe, one cycle after the request |
| respAccept | output | 1 | 1 when the request was accepted |
| statusByte | output | 8 | Current status register value |

## Verification
The hardest cases to reach are the edges of the lower-range protect codes, where a one-page or one-sector shift in the target address flips the verdict. Each code first has to be written through the status-write path, and that path is itself gated by the latch, the busy period and the hardware lock. The bench uses a helper that sets the latch, writes a protect code and waits out the busy period. A second helper then sets the latch again, issues the program or erase just inside and just outside each boundary, and clears the latch after a rejection so the next probe starts clean. The hardware lock is reached by first writing the lock bit with the pin high and then lowering the pin.

// File: rtl/nor_guard_pkg.sv
package nor_guard_pkg;

  typedef enum logic [2:0] {
    K_RDSR  = 3'd0,
    K_WREN  = 3'd1,
    K_WRDI  = 3'd2,
    K_WRSR  = 3'd3,
    K_PROG  = 3'd4,
    K_ERASE = 3'd5
  } reqKind_e;

  localparam logic [1:0] SZ_SECTOR = 2'd0;
  localparam logic [1:0] SZ_BLOCK  = 2'd1;
  localparam logic [1:0] SZ_CHIP   = 2'd2;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadSr;
    logic startBusy;
  } strobe_t;

endpackage

// File: rtl/nor_guard_dp.sv
module nor_guard_dp
  import nor_guard_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int BUSY_CYCLES = 8,
  parameter int PAGE_W      = 8,
  parameter int SECTOR_W    = 12,
  parameter int BLOCK_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  strobe_t     strb,
  input  logic [7:0]  reqData,
  input  logic [23:0] reqAddr,
  input  logic [2:0]  reqKind,
  input  logic [1:0]  reqSize,
  output logic        wip,
  output logic        wel,
  output logic        srp,
  output logic [3:0]  bp,
  output logic        hitProt,
  output logic [7:0]  statusByte
);
  localparam int CNT_W     = $clog2(BUSY_CYCLES + 1);
  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int BLK       = 1 << BLOCK_W;
  localparam int SEC       = 1 << SECTOR_W;
  localparam logic [ADDR_W-1:0] LAST     = '1;
  localparam logic [ADDR_W-1:0] PAGE_MSK = ADDR_W'((1 << PAGE_W) - 1);
  localparam logic [ADDR_W-1:0] SEC_MSK  = ADDR_W'(SEC - 1);
  localparam logic [ADDR_W-1:0] BLK_MSK  = ADDR_W'(BLK - 1);

  logic [CNT_W-1:0]  busyCnt;
  logic [3:0]        bpReg;
  logic              srpReg, welReg;
  logic              protAny;
  logic [ADDR_W-1:0] pLo, pHi, tAddr, tMask, tLo, tHi;
  logic              unusedDataBits;

  assign unusedDataBits = ^{reqData[6], reqData[1:0], reqAddr[23:ADDR_W]};

  // Protected range selected by the protect code
  always_comb begin
    protAny = 1'b1;
    pLo     = '0;
    pHi     = LAST;
    case (bpReg)
      4'b0000, 4'b1000: protAny = 1'b0;
      4'b0001: pLo = ADDR_W'(MEM_BYTES - BLK);
      4'b0010: pLo = ADDR_W'(MEM_BYTES - 2 * BLK);
      4'b0011: pLo = ADDR_W'(MEM_BYTES - 4 * BLK);
      4'b1001: pHi = ADDR_W'(MEM_BYTES - SEC - 1);
      4'b1010: pHi = ADDR_W'(MEM_BYTES - 2 * SEC - 1);
      4'b1011: pHi = ADDR_W'(MEM_BYTES - 4 * SEC - 1);
      4'b1100: pHi = ADDR_W'(MEM_BYTES - 8 * SEC - 1);
      4'b1101: pHi = ADDR_W'(MEM_BYTES - 2 * BLK - 1);
      4'b1110: pHi = ADDR_W'(MEM_BYTES - 4 * BLK - 1);
      default: ; // whole array
    endcase
  end

  // Target span of the request
  assign tAddr = reqAddr[ADDR_W-1:0];
  always_comb begin
    if (reqKind == K_PROG)           tMask = PAGE_MSK;
    else if (reqSize == SZ_SECTOR)   tMask = SEC_MSK;
    else if (reqSize == SZ_BLOCK)    tMask = BLK_MSK;
    else                             tMask = LAST;
  end
  assign tLo     = tAddr & ~tMask;
  assign tHi     = tAddr | tMask;
  assign hitProt = protAny && (tLo <= pHi) && (tHi >= pLo);

  // Status state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpReg   <= '0;
      srpReg  <= 1'b0;
      welReg  <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (strb.loadSr) begin
        bpReg  <= reqData[5:2];
        srpReg <= reqData[7];
      end
      if (strb.setWel)
        welReg <= 1'b1;
      else if (strb.clrWel || busyCnt == CNT_W'(1))
        welReg <= 1'b0;
      if (strb.startBusy)
        busyCnt <= CNT_W'(BUSY_CYCLES);
      else if (busyCnt != '0)
        busyCnt <= busyCnt - CNT_W'(1);
    end
  end

  assign wip        = (busyCnt != '0);
  assign wel        = welReg;
  assign srp        = srpReg;
  assign bp         = bpReg;
  assign statusByte = {srpReg, 1'b0, bpReg, welReg, wip};

endmodule

// File: rtl/nor_guard_ctrl.sv
module nor_guard_ctrl
  import nor_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  input  logic [1:0] reqSize,
  input  logic       wpN,
  input  logic       wip,
  input  logic       wel,
  input  logic       srp,
  input  logic [3:0] bp,
  input  logic       hitProt,
  output strobe_t    strb,
  output logic       respValid,
  output logic       respAccept
);
  logic    ok;
  logic    writeOk;
  strobe_t want;

  assign writeOk = wel && !wip;

  always_comb begin
    ok   = 1'b0;
    want = '0;
    case (reqKind)
      K_RDSR: ok = 1'b1;
      K_WREN: begin ok = !wip; want.setWel = 1'b1; end
      K_WRDI: begin ok = !wip; want.clrWel = 1'b1; end
      K_WRSR: begin
        ok = writeOk && !(srp && !wpN);
        want.loadSr    = 1'b1;
        want.startBusy = 1'b1;
      end
      K_PROG: begin
        ok = writeOk && !hitProt;
        want.startBusy = 1'b1;
      end
      K_ERASE: begin
        if (reqSize == SZ_CHIP)
          ok = writeOk && (bp == 4'b0000);
        else if (reqSize == 2'd3)
          ok = 1'b0;
        else
          ok = writeOk && !hitProt;
        want.startBusy = 1'b1;
      end
      default: ok = 1'b0;
    endcase
  end

  assign strb = (reqValid && ok) ? want : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid  <= 1'b0;
      respAccept <= 1'b0;
    end else begin
      respValid  <= reqValid;
      respAccept <= reqValid && ok;
    end
  end

endmodule

// File: rtl/nor_status_guard.sv
module nor_status_guard
  import nor_guard_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int BUSY_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic [2:0]  reqKind,
  input  logic [7:0]  reqData,
  input  logic [23:0] reqAddr,
  input  logic [1:0]  reqSize,
  input  logic        wpN,
  output logic        respValid,
  output logic        respAccept,
  output logic [7:0]  statusByte
);
  strobe_t    strb;
  logic       wip, wel, srp, hitProt;
  logic [3:0] bp;

  nor_guard_ctrl u_ctrl (
    .clk, .rst_n, .reqValid, .reqKind, .reqSize, .wpN,
    .wip, .wel, .srp, .bp, .hitProt,
    .strb, .respValid, .respAccept
  );

  nor_guard_dp #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_dp (
    .clk, .rst_n, .strb, .reqData, .reqAddr, .reqKind, .reqSize,
    .wip, .wel, .srp, .bp, .hitProt, .statusByte
  );

endmodule

// File: rtl/nor_status_guard_chk.sv
module nor_status_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reqValid,
  input logic [2:0]  reqKind,
  input logic [7:0]  reqData,
  input logic [23:0] reqAddr,
  input logic [1:0]  reqSize,
  input logic        wpN,
  input logic        respValid,
  input logic        respAccept,
  input logic [7:0]  statusByte
);
  logic writeKind;
  assign writeKind = (reqKind == 3'd3) || (reqKind == 3'd4) || (reqKind == 3'd5);

  // R3
  no_write_without_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && writeKind && !statusByte[1] |=> !respAccept);

  // R12
  busy_rejects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && statusByte[0] && reqKind != 3'd0 |=> !respAccept);

  // R5
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqKind == 3'd3 && statusByte[7] && !wpN |=> !respAccept && $stable(statusByte[7:2]));

  // R2
  wrdi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqKind == 3'd2 && !statusByte[0] |=> !statusByte[1]);

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusByte[0]) |-> respValid && respAccept);

  // R10
  chip_erase_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqKind == 3'd5 && reqSize == 2'd2 && statusByte[5:2] != 4'd0 |=> !respAccept);

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> $past(reqValid));

  logic unusedChk;
  assign unusedChk = ^{reqData, reqAddr};
endmodule

bind nor_status_guard nor_status_guard_chk u_chk (.*);

// File: tb/nor_status_guard_bench.sv
module nor_status_guard_bench;
  localparam int BUSY = 8;

  logic        clk = 0, rst_n = 0;
  logic        reqValid = 0;
  logic [2:0]  reqKind = 0;
  logic [7:0]  reqData = 0;
  logic [23:0] reqAddr = 0;
  logic [1:0]  reqSize = 0;
  logic        wpN = 1;
  logic        respValid, respAccept;
  logic [7:0]  statusByte;

  int checks = 0, failures = 0;
  bit done = 0;

  nor_status_guard #(.ADDR_W(19), .BUSY_CYCLES(BUSY)) u_nor_status_guard (.*);

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic lastAcc;
  logic [7:0] lastSt;

  task automatic doReq(input logic [2:0] k, input logic [7:0] d = 0,
                       input logic [23:0] a = 0, input logic [1:0] s = 0);
    @(negedge clk);
    reqKind = k; reqData = d; reqAddr = a; reqSize = s; reqValid = 1;
    @(posedge clk); #1;
    lastAcc = respAccept; lastSt = statusByte;
    reqValid = 0;
  endtask

  task automatic waitIdle();
    while (statusByte[0]) begin @(posedge clk); #1; end
  endtask

  task automatic setBp(input logic [3:0] code);
    doReq(3'd1);
    doReq(3'd3, {2'b00, code, 2'b00});
    waitIdle();
  endtask

  task automatic tryOp(input string tag, input logic [2:0] k, input logic [23:0] a,
                       input logic [1:0] s, input logic exp);
    doReq(3'd1);
    doReq(k, 8'h00, a, s);
    check(tag, lastAcc, exp);
    if (lastAcc) waitIdle(); else doReq(3'd2);
  endtask

  task automatic testReset();
    check("R1 reset status", statusByte, 8'h00);
    check("R1 reset resp", respValid, 1'b0);
  endtask

  task automatic testWel();
    doReq(3'd3, 8'h3C); check("R3 wrsr no wel", lastAcc, 0);
    check("R3 status unchanged", lastSt, 8'h00);
    doReq(3'd4, 8'h00, 24'h000100); check("R3 prog no wel", lastAcc, 0);
    doReq(3'd5, 8'h00, 24'h001000, 2'd0); check("R3 erase no wel", lastAcc, 0);
    doReq(3'd1); check("R2 wren acc", lastAcc, 1); check("R2 wel set", lastSt, 8'h02);
    doReq(3'd2); check("R2 wrdi acc", lastAcc, 1); check("R2 wel clr", lastSt, 8'h00);
    doReq(3'd7); check("R2 bad kind", lastAcc, 0);
  endtask

  task automatic testWrsrBusy();
    int n;
    doReq(3'd1);
    doReq(3'd3, 8'hFF);
    check("R4 wrsr acc", lastAcc, 1);
    check("R4 status after write", lastSt, 8'hBF);
    doReq(3'd1); check("R12 wren busy", lastAcc, 0);
    doReq(3'd2); check("R12 wrdi busy", lastAcc, 0);
    doReq(3'd0); check("R12 rdsr busy", lastAcc, 1);
    n = 3;
    while (statusByte[0]) begin n++; @(posedge clk); #1; end
    check("R11 busy length", n, BUSY);
    check("R11 wel cleared", statusByte, 8'hBC);
  endtask

  task automatic testHwLock();
    wpN = 0;
    doReq(3'd1);
    doReq(3'd3, 8'h00); check("R5 locked wrsr", lastAcc, 0);
    check("R5 status held", lastSt, 8'hBE);
    wpN = 1;
    doReq(3'd3, 8'h00); check("R5 unlocked wrsr", lastAcc, 1);
    waitIdle();
    check("R5 status cleared", statusByte, 8'h00);
  endtask

  task automatic testTop();
    setBp(4'b0001);
    tryOp("R6 c1 page below", 3'd4, 24'h06FF00, 0, 1);
    tryOp("R6 c1 page top", 3'd4, 24'h070000, 0, 0);
    tryOp("R9 c1 block below", 3'd5, 24'h060000, 1, 1);
    setBp(4'b0010);
    tryOp("R6 c2 block", 3'd5, 24'h060000, 1, 0);
    tryOp("R6 c2 block below", 3'd5, 24'h05FFFF, 1, 1);
    setBp(4'b0011);
    tryOp("R6 c3 page below", 3'd4, 24'h03FF00, 0, 1);
    tryOp("R6 c3 sector", 3'd5, 24'h040000, 0, 0);
  endtask

  task automatic testAllNone();
    setBp(4'b0100); tryOp("R7 c4 low", 3'd4, 24'h000000, 0, 0);
    setBp(4'b0111); tryOp("R7 c7 top", 3'd4, 24'h07FF00, 0, 0);
    setBp(4'b1111); tryOp("R7 c15 low", 3'd4, 24'h000000, 0, 0);
    setBp(4'b1000); tryOp("R7 c8 top", 3'd4, 24'h07FF00, 0, 1);
    tryOp("R10 c8 chip erase", 3'd5, 24'h0, 2, 0);
    setBp(4'b0001); tryOp("R10 c1 chip erase", 3'd5, 24'h0, 2, 0);
    setBp(4'b0000);
    tryOp("R7 c0 top", 3'd4, 24'h07FF00, 0, 1);
    tryOp("R9 size3 erase", 3'd5, 24'h0, 3, 0);
    tryOp("R10 c0 chip erase", 3'd5, 24'h0, 2, 1);
  endtask

  task automatic testLower();
    setBp(4'b1001);
    tryOp("R8 c9 top page", 3'd4, 24'h07F000, 0, 1);
    tryOp("R8 c9 edge page", 3'd4, 24'h07EF00, 0, 0);
    tryOp("R9 c9 top block", 3'd5, 24'h070000, 1, 0);
    setBp(4'b1010);
    tryOp("R8 c10 sector in", 3'd5, 24'h07E000, 0, 1);
    tryOp("R8 c10 sector out", 3'd5, 24'h07D000, 0, 0);
    setBp(4'b1011);
    tryOp("R8 c11 sector in", 3'd5, 24'h07C000, 0, 1);
    tryOp("R8 c11 sector out", 3'd5, 24'h07B000, 0, 0);
    setBp(4'b1100);
    tryOp("R8 c12 sector in", 3'd5, 24'h078000, 0, 1);
    tryOp("R8 c12 sector out", 3'd5, 24'h077000, 0, 0);
    setBp(4'b1101);
    tryOp("R8 c13 block in", 3'd5, 24'h060000, 1, 1);
    tryOp("R8 c13 block out", 3'd5, 24'h050000, 1, 0);
    setBp(4'b1110);
    tryOp("R8 c14 page in", 3'd4, 24'h040000, 0, 1);
    tryOp("R8 c14 page out", 3'd4, 24'h03FF00, 0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1; testReset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    testReset();
    testWel();
    testWrsrBusy();
    testHwLock();
    testTop();
    testAllNone();
    testLower();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule